// File: doc/BRIEF.md
# CPU Clock Burst Power Controller

This block saves power by letting the CPU clock run for only part of a repeating frame. The frame is `SLOTS` time slots long, 31 by default, and each slot lasts `SLOT_DIV` clock cycles. Software programs a burst width, which is the number of slots per frame in which the CPU clock may run. When the CPU's share of the frame ends, the block requests the bus from the CPU. It stops the CPU clock only after the CPU grants the bus. While the CPU clock is stopped, the bus belongs to a DMA requester.

A wakeup interrupt restores the continuous clock. It does this by clearing the controller enable, so the clock stays on until software enables the controller again. DMA always has priority. The CPU clock is not restarted while the DMA requester still holds the bus. Software reads back the enable bit and the width to learn whether a wakeup has ended burst mode.

Top module: `cpu_burst_pwr_ctl`

## Requirements
- R1: After reset the enable is 0, the width reads `SLOTS`, `cpu_clk_en` is 1, and `bus_req` and `dma_gnt` are 0.
- R2: A write with `wr_sel`=0 and `wr_data[0]`=1, made while the controller is disabled, sets the enable and loads the width with `SLOTS` (100% duty). The clock then stays on.
- R3: A write with `wr_sel`=1 stores `wr_data` as the width, whether or not the controller is enabled. The width reads back on `sw_width` on the next cycle.
- R4: While enabled, a slot counter advances once every `SLOT_DIV` cycles and wraps after `SLOTS` slots. The CPU may run while the counter is below the width. A width of `SLOTS` or more keeps the clock on.
- R5: When the CPU's slot ends, `bus_req` rises. `cpu_clk_en` falls only on the cycle after `bus_req` and `bus_gnt` were both high.
- R6: `dma_gnt` is high only while the CPU clock is stopped and `dma_req` is high.
- R7: `wake_irq` clears the enable on the next edge, and it takes precedence over a write in the same cycle.
- R8: While the CPU clock is stopped and `dma_req` is high, the clock stays stopped.
- R9: When the CPU slot returns, or a wakeup is pending, and `dma_req` is low, the clock restarts and `bus_req` drops on the next edge. A wakeup or a returning slot while the request is waiting for a grant cancels the request.
- R10: With the width at 0, the CPU clock stays off for the whole frame once it has stopped.
- R11: While the controller is disabled, the CPU clock never stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: control (bit 0 = enable), 1: burst width |
| wr_data | input | WW | Write data |
| wake_irq | input | 1 | Wakeup interrupt |
| bus_gnt | input | 1 | Bus grant from the CPU |
| dma_req | input | 1 | Bus request from the DMA requester |
| cpu_clk_en | output | 1 | Enable for the CPU clock gate |
| bus_req | output | 1 | Bus request to the CPU |
| dma_gnt | output | 1 | Bus grant to the DMA requester |
| sw_en | output | 1 | Readback of the enable bit |
| sw_width | output | WW | Readback of the burst width |

## Verification
Every register result is due one edge after its cause:
- a write or wakeup changes `sw_en` and `sw_width` on the next edge;
- the state moves one edge after the slot counter, grant or DMA input that triggers it.

`dma_gnt` follows `dma_req` in the same cycle while the clock is stopped. The bench drives its inputs on the falling edge. A behavioural model steps on the rising edge from those inputs, and every output is compared 2 ns after each rising edge. The directed checks wait exactly one rising edge after the stimulus before they sample.

// File: rtl/cpu_burst_pwr_ctl.sv
module cpu_burst_pwr_ctl #(
  parameter int SLOTS    = 31,
  parameter int SLOT_DIV = 4,
  localparam int WW = $clog2(SLOTS + 1),
  localparam int PW = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [WW-1:0] wr_data,
  input  logic          wake_irq,
  input  logic          bus_gnt,
  input  logic          dma_req,
  output logic          cpu_clk_en,
  output logic          bus_req,
  output logic          dma_gnt,
  output logic          sw_en,
  output logic [WW-1:0] sw_width
);

  typedef enum logic [1:0] {RUN, ASK, HALT} st_t;

  st_t           st_q;
  logic          en_q;
  logic [WW-1:0] width_q;
  logic [PW-1:0] pre_q;
  logic [SW-1:0] slot_q;
  logic          tick, slot_on;

  assign tick    = pre_q == PW'(SLOT_DIV - 1);
  assign slot_on = !en_q || (width_q >= WW'(SLOTS)) || ({1'b0, slot_q} < {1'b0, width_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      width_q <= WW'(SLOTS);
    end else begin
      if (wr_en && wr_sel) width_q <= wr_data;
      if (wr_en && !wr_sel && wr_data[0] && !en_q) width_q <= WW'(SLOTS);
      if (wake_irq) en_q <= 1'b0;
      else if (wr_en && !wr_sel) en_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else if (!en_q) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else if (tick) begin
      pre_q  <= '0;
      slot_q <= (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RUN;
    else case (st_q)
      RUN:     if (!slot_on) st_q <= ASK;
      ASK:     if (slot_on || wake_irq) st_q <= RUN;
               else if (bus_gnt) st_q <= HALT;
      HALT:    if ((slot_on || wake_irq) && !dma_req) st_q <= RUN;
      default: st_q <= RUN;
    endcase
  end

  assign cpu_clk_en = st_q != HALT;
  assign bus_req    = st_q != RUN;
  assign dma_gnt    = (st_q == HALT) && dma_req;
  assign sw_en      = en_q;
  assign sw_width   = width_q;

  p_stop_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> $past(bus_req && bus_gnt));
  p_dma_only_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt |-> (!cpu_clk_en && bus_req));
  p_wake_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !sw_en);
  p_dma_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && dma_req) |=> !cpu_clk_en);
  p_disabled_runs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && cpu_clk_en) |=> cpu_clk_en);
  p_enable_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[0] && !sw_en && !wake_irq) |=> (sw_en && sw_width == WW'(SLOTS)));

endmodule

// File: tb/cpu_burst_pwr_ctl_test.sv
module cpu_burst_pwr_ctl_test;
  localparam int SLOTS = 31, DIV = 4, WW = $clog2(SLOTS + 1);

  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0, wake_irq = 0, bus_gnt = 0, dma_req = 0;
  logic [WW-1:0] wr_data = '0;
  logic cpu_clk_en, bus_req, dma_gnt, sw_en;
  logic [WW-1:0] sw_width;
  int checks = 0, errors = 0;
  bit done = 0;

  cpu_burst_pwr_ctl #(.SLOTS(SLOTS), .SLOT_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wake_irq(wake_irq), .bus_gnt(bus_gnt), .dma_req(dma_req),
    .cpu_clk_en(cpu_clk_en), .bus_req(bus_req), .dma_gnt(dma_gnt),
    .sw_en(sw_en), .sw_width(sw_width));

  always #5 clk = ~clk;

  // reference model: 0 running, 1 asking, 2 halted
  int m_en = 0, m_w = SLOTS, m_pre = 0, m_slot = 0, m_st = 0;
  always @(posedge clk) begin
    int n_en, n_w, n_pre, n_slot, n_st;
    bit on;
    if (!rst_n) begin
      m_en = 0; m_w = SLOTS; m_pre = 0; m_slot = 0; m_st = 0;
    end else begin
      on = (m_en == 0) || (m_w >= SLOTS) || (m_slot < m_w);
      n_en = m_en; n_w = m_w; n_pre = m_pre; n_slot = m_slot; n_st = m_st;
      if (wr_en && wr_sel) n_w = int'(wr_data);
      if (wr_en && !wr_sel && wr_data[0] && m_en == 0) n_w = SLOTS;
      if (wake_irq) n_en = 0;
      else if (wr_en && !wr_sel) n_en = int'(wr_data[0]);
      if (m_en == 0) begin n_pre = 0; n_slot = 0; end
      else if (m_pre == DIV - 1) begin n_pre = 0; n_slot = (m_slot + 1) % SLOTS; end
      else n_pre = m_pre + 1;
      if (m_st == 0 && !on) n_st = 1;
      else if (m_st == 1) begin
        if (on || wake_irq) n_st = 0; else if (bus_gnt) n_st = 2;
      end else if (m_st == 2 && (on || wake_irq) && !dma_req) n_st = 0;
      m_en = n_en; m_w = n_w; m_pre = n_pre; m_slot = n_slot; m_st = n_st;
    end
    #2;
    if (rst_n && !done) begin
      chk(int'(cpu_clk_en), int'(m_st != 2), "R4 cpu_clk_en");
      chk(int'(bus_req), int'(m_st != 0), "R5 bus_req");
      chk(int'(dma_gnt), int'(m_st == 2 && dma_req), "R6 dma_gnt");
      chk(int'(sw_en), m_en, "R7 sw_en");
      chk(int'(sw_width), m_w, "R3 sw_width");
    end
  end

  always @(negedge clk) bus_gnt <= bus_req;

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(bit sel, int data);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = WW'(data);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lows;
    idle(3);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(int'(sw_en), 0, "R1 enable");
    chk(int'(sw_width), SLOTS, "R1 width");
    chk(int'(cpu_clk_en), 1, "R1 clk_en");
    chk(int'(bus_req) + int'(dma_gnt), 0, "R1 bus");
    // R11 disabled: never stops, even with a narrow width stored (R3)
    wr(1, 3);
    chk(int'(sw_width), 3, "R3 width while disabled");
    lows = 0;
    repeat (300) begin @(negedge clk); if (!cpu_clk_en) lows++; end
    chk(lows, 0, "R11 clock held while disabled");
    // R2 enable loads full width, clock stays on
    wr(0, 1);
    chk(int'(sw_width), SLOTS, "R2 width full");
    chk(int'(sw_en), 1, "R2 enabled");
    lows = 0;
    repeat (400) begin @(negedge clk); if (!cpu_clk_en) lows++; end
    chk(lows, 0, "R2 continuous at full width");
    // R4 partial width bursting, with DMA traffic
    wr(1, 10);
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk); dma_req = (i % 7) < 3;
    end
    // R10 width 0: clock off across a full frame once stopped
    dma_req = 1;
    wr(1, 0);
    idle(20);
    lows = 0;
    repeat (SLOTS * DIV) begin @(negedge clk); if (cpu_clk_en) lows++; end
    chk(lows, 0, "R10 no clock at width zero");
    // R7/R8 wakeup while DMA holds the bus
    @(negedge clk); wake_irq = 1;
    @(negedge clk); wake_irq = 0;
    chk(int'(sw_en), 0, "R7 wake clears enable");
    repeat (5) begin @(negedge clk); chk(int'(cpu_clk_en), 0, "R8 DMA keeps bus"); end
    dma_req = 0;
    @(posedge clk); #2;
    chk(int'(cpu_clk_en), 1, "R9 clock back after DMA ends");
    chk(int'(bus_req), 0, "R9 request dropped");
    // R7 wake wins over a same-cycle enable write
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 1; wake_irq = 1;
    @(negedge clk); wr_en = 0; wake_irq = 0;
    chk(int'(sw_en), 0, "R7 wake over write");
    // mixed traffic with random wakeups and re-enables
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      dma_req  = ($urandom % 4) == 0;
      wake_irq = ($urandom % 500) == 0;
      if (!sw_en && ($urandom % 50) == 0) begin
        wr_en = 1; wr_sel = 0; wr_data = 1;
      end else if (($urandom % 300) == 0) begin
        wr_en = 1; wr_sel = 1; wr_data = WW'($urandom % 32);
      end else wr_en = 0;
    end
    @(negedge clk); wr_en = 0; wake_irq = 0; dma_req = 0;
    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule